// File: doc/BRIEF.md
# Indirect Burst Write Engine

This block gives a host a small window of byte-wide control registers through which it stages a burst of up to sixteen bytes and then hands that burst to one of two consumers. The host sets a byte count, a destination byte and the payload. It then writes an operation register. One operation bit copies the staged bytes into an internal register file, one write per clock, at consecutive addresses. The other bit relays the same bytes to an external I2C device, using a beat-level request interface to an I2C master that lives elsewhere.

Each operation bit stays set while its operation runs, so the host polls it to see when the burst has finished. The relay records whether the remote device refused a byte. It also exposes a transfer-speed byte that the external master can use. Bit timing on the I2C wires is not part of this block.

Top module: `burst_write_engine`

## Requirements
- R1: After a synchronous reset every host register reads 0: speed (0x20), operation/status (0x21), length (0x34) and destination (0x35). Neither `rf_we` nor `i2c_valid` is asserted.
- R2: Writing register 0x34 stores the byte count, clamped to DEPTH (16), and rewinds the staging pointer to 0. The stored count reads back at 0x34.
- R3: Each write to the window at 0x36 stores the next payload byte in order. A window write made once the pointer has reached the staged count is ignored.
- R4: Writing 0x21 with bit 1 (0x02) set while idle starts the internal copy. Starting the cycle after that write, the block asserts `rf_we` once per cycle, for byte i at address (destination + i) mod 256. Bit 1 of 0x21 reads 1 until the copy ends and 0 afterwards. A count of zero produces no writes.
- R5: Writing 0x21 with bit 7 (0x80) set, and bit 1 clear, starts the relay. The relay issues these beats on `i2c_kind`, in this order:
  - an address beat (kind 0) carrying the destination byte;
  - one data beat (kind 1) per staged byte, in order;
  - a stop beat (kind 2).
  Bit 7 of 0x21 reads 1 until the stop beat is accepted. When bits 1 and 7 are both written, only the copy runs.
- R6: If `i2c_nack` is high when an address or data beat is accepted, the relay sets status bit 0 of 0x21 and goes straight to the stop beat, skipping the remaining data. Bit 0 clears when the next relay starts.
- R7: While either operation is busy, writes to 0x21, 0x34, 0x35 and 0x36 are ignored.
- R8: Register 0x20 holds a relay speed byte, writable at any time. It reads back at 0x20 and drives `relay_speed`.
- R9: A beat is accepted on a cycle with `i2c_valid` and `i2c_ready` both high. While `i2c_valid` is high and `i2c_ready` is low, the beat's kind and byte stay unchanged. `rf_we` and `i2c_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register address (also selects read data) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| rf_we | output | 1 | Internal register-file write enable |
| rf_addr | output | 8 | Internal register-file address |
| rf_data | output | 8 | Internal register-file data |
| relay_speed | output | 8 | Speed byte for the external I2C master |
| i2c_valid | output | 1 | Relay beat request valid |
| i2c_kind | output | 2 | Beat kind: 0 address, 1 data, 2 stop |
| i2c_byte | output | 8 | Address or data byte of the beat |
| i2c_ready | input | 1 | Master accepts the current beat |
| i2c_nack | input | 1 | Remote device refused the accepted beat |

## Verification
The table covers copies of one, four and sixteen bytes, a copy that wraps past address 0xFF, and a zero-length copy, so that the address arithmetic and the end-of-burst test are each exposed on their own. Relays run with no refusal, with a refusal on the address beat, with a refusal on the first data byte, and with an empty payload. These cases separate full payload delivery from an early jump to stop, and show whether the refusal flag is set correctly. Directed cases cover the window overrun and the pointer rewind, length clamping, simultaneous operation bits, and a stalled master during which every staging and trigger write must be ignored and the pending beat held.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam logic [7:0] REG_SPEED = 8'h20;
    localparam logic [7:0] REG_OP    = 8'h21;
    localparam logic [7:0] REG_LEN   = 8'h34;
    localparam logic [7:0] REG_DEST  = 8'h35;
    localparam logic [7:0] REG_WIN   = 8'h36;

    localparam int OP_NACK_BIT  = 0;
    localparam int OP_COPY_BIT  = 1;
    localparam int OP_RELAY_BIT = 7;

    typedef enum logic [1:0] {
        BEAT_ADDR = 2'd0,
        BEAT_DATA = 2'd1,
        BEAT_STOP = 2'd2
    } beat_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_COPY,
        SQ_ADDR,
        SQ_DATA,
        SQ_STOP
    } seq_e;

    typedef struct packed {
        logic       valid;
        beat_e      kind;
        logic [7:0] data;
    } beat_t;

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
    } rfw_t;

    function automatic logic [7:0] clamp_len(logic [7:0] req, int depth);
        return (req > depth[7:0]) ? depth[7:0] : req;
    endfunction

endpackage

// File: rtl/burst_stage.sv
module burst_stage
    import burst_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LENW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            len_we,
    input  logic [7:0]      len_in,
    input  logic            win_we,
    input  logic [7:0]      win_data,
    input  logic [LENW-1:0] rd_idx,
    output logic [LENW-1:0] len_q,
    output logic [7:0]      rd_byte
);

    logic [LENW-1:0] wptr_q;
    logic [7:0]      mem_q [DEPTH];
    logic [7:0]      len_c;
    logic            accept;

    assign len_c  = clamp_len(len_in, DEPTH);
    assign accept = win_we && (wptr_q < len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            wptr_q <= '0;
        end else if (len_we) begin
            len_q  <= len_c[LENW-1:0];
            wptr_q <= '0;
        end else if (accept) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[g] <= '0;
            else if (accept && (wptr_q == LENW'(g)))
                mem_q[g] <= win_data;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == LENW'(i))
                rd_byte = mem_q[i];
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int LENW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_copy,
    input  logic            start_relay,
    input  logic [LENW-1:0] len,
    input  logic [7:0]      dest,
    input  logic [7:0]      cur_byte,
    input  logic            bus_ready,
    input  logic            bus_nack,
    output logic [LENW-1:0] idx,
    output rfw_t            rfw,
    output beat_t           beat,
    output logic            copy_busy,
    output logic            relay_busy,
    output logic            nack_flag
);

    seq_e state_q;
    logic at_end;

    assign at_end = (idx == len);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            idx       <= '0;
            nack_flag <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    idx <= '0;
                    if (start_copy) begin
                        state_q <= SQ_COPY;
                    end else if (start_relay) begin
                        state_q   <= SQ_ADDR;
                        nack_flag <= 1'b0;
                    end
                end
                SQ_COPY: begin
                    if (at_end) state_q <= SQ_IDLE;
                    else        idx     <= idx + 1'b1;
                end
                SQ_ADDR: begin
                    if (bus_ready) begin
                        if (bus_nack) begin
                            nack_flag <= 1'b1;
                            state_q   <= SQ_STOP;
                        end else begin
                            state_q   <= SQ_DATA;
                        end
                    end
                end
                SQ_DATA: begin
                    if (at_end) begin
                        state_q <= SQ_STOP;
                    end else if (bus_ready) begin
                        idx <= idx + 1'b1;
                        if (bus_nack) begin
                            nack_flag <= 1'b1;
                            state_q   <= SQ_STOP;
                        end
                    end
                end
                SQ_STOP: begin
                    if (bus_ready) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        rfw.we   = (state_q == SQ_COPY) && !at_end;
        rfw.addr = dest + 8'(idx);
        rfw.data = cur_byte;

        beat.valid = 1'b0;
        beat.kind  = BEAT_ADDR;
        beat.data  = dest;
        case (state_q)
            SQ_ADDR: beat.valid = 1'b1;
            SQ_DATA: begin
                beat.valid = !at_end;
                beat.kind  = BEAT_DATA;
                beat.data  = cur_byte;
            end
            SQ_STOP: begin
                beat.valid = 1'b1;
                beat.kind  = BEAT_STOP;
                beat.data  = 8'h00;
            end
            default: ;
        endcase
    end

    assign copy_busy  = (state_q == SQ_COPY);
    assign relay_busy = (state_q == SQ_ADDR) || (state_q == SQ_DATA) || (state_q == SQ_STOP);

endmodule

// File: rtl/burst_write_engine.sv
module burst_write_engine
    import burst_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_we,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       rf_we,
    output logic [7:0] rf_addr,
    output logic [7:0] rf_data,
    output logic [7:0] relay_speed,
    output logic       i2c_valid,
    output logic [1:0] i2c_kind,
    output logic [7:0] i2c_byte,
    input  logic       i2c_ready,
    input  logic       i2c_nack
);

    localparam int LENW = $clog2(DEPTH + 1);

    logic [7:0]      speed_q;
    logic [7:0]      dest_q;
    logic [LENW-1:0] len_q;
    logic [LENW-1:0] idx;
    logic [7:0]      cur_byte;
    logic            copy_busy, relay_busy, nack_flag;
    logic            idle, len_we, win_we, op_we;
    rfw_t            rfw;
    beat_t           beat;

    assign idle   = !copy_busy && !relay_busy;
    assign len_we = host_we && idle && (host_addr == REG_LEN);
    assign win_we = host_we && idle && (host_addr == REG_WIN);
    assign op_we  = host_we && idle && (host_addr == REG_OP);

    always_ff @(posedge clk) begin
        if (rst) begin
            speed_q <= '0;
            dest_q  <= '0;
        end else begin
            if (host_we && (host_addr == REG_SPEED))
                speed_q <= host_wdata;
            if (host_we && idle && (host_addr == REG_DEST))
                dest_q <= host_wdata;
        end
    end

    burst_stage #(.DEPTH(DEPTH), .LENW(LENW)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .len_we   (len_we),
        .len_in   (host_wdata),
        .win_we   (win_we),
        .win_data (host_wdata),
        .rd_idx   (idx),
        .len_q    (len_q),
        .rd_byte  (cur_byte)
    );

    burst_seq #(.LENW(LENW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_copy  (op_we && host_wdata[OP_COPY_BIT]),
        .start_relay (op_we && host_wdata[OP_RELAY_BIT] && !host_wdata[OP_COPY_BIT]),
        .len         (len_q),
        .dest        (dest_q),
        .cur_byte    (cur_byte),
        .bus_ready   (i2c_ready),
        .bus_nack    (i2c_nack),
        .idx         (idx),
        .rfw         (rfw),
        .beat        (beat),
        .copy_busy   (copy_busy),
        .relay_busy  (relay_busy),
        .nack_flag   (nack_flag)
    );

    always_comb begin
        case (host_addr)
            REG_SPEED: host_rdata = speed_q;
            REG_OP:    host_rdata = {relay_busy, 5'b0, copy_busy, nack_flag};
            REG_LEN:   host_rdata = 8'(len_q);
            REG_DEST:  host_rdata = dest_q;
            default:   host_rdata = 8'h00;
        endcase
    end

    assign rf_we       = rfw.we;
    assign rf_addr     = rfw.addr;
    assign rf_data     = rfw.data;
    assign relay_speed = speed_q;
    assign i2c_valid   = beat.valid;
    assign i2c_kind    = beat.kind;
    assign i2c_byte    = beat.data;

endmodule

// File: rtl/burst_engine_chk.sv
module burst_engine_chk
    import burst_pkg::*;
#(
    parameter int LENW = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            host_we,
    input logic [7:0]      host_addr,
    input logic            rf_we,
    input logic            i2c_valid,
    input logic [1:0]      i2c_kind,
    input logic [7:0]      i2c_byte,
    input logic            i2c_ready,
    input logic            copy_busy,
    input logic            relay_busy,
    input logic [LENW-1:0] len_q
);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (i2c_valid && !i2c_ready) |=> (i2c_valid && $stable(i2c_kind) && $stable(i2c_byte)));

    assert_one_port_R9: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && i2c_valid));

    assert_len_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        ((copy_busy || relay_busy) && host_we && (host_addr == REG_LEN)) |=> $stable(len_q));

    assert_addr_first_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(relay_busy) |-> (i2c_valid && (i2c_kind == 2'd0)));

    assert_no_beat_in_copy_R4: assert property (@(posedge clk) disable iff (rst)
        copy_busy |-> !i2c_valid);

endmodule

bind burst_write_engine burst_engine_chk #(.LENW(LENW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .rf_we      (rf_we),
    .i2c_valid  (i2c_valid),
    .i2c_kind   (i2c_kind),
    .i2c_byte   (i2c_byte),
    .i2c_ready  (i2c_ready),
    .copy_busy  (copy_busy),
    .relay_busy (relay_busy),
    .len_q      (len_q)
);

// File: tb/burst_write_engine_bench.sv
module burst_write_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_SPEED = 8'h20, A_OP = 8'h21, A_LEN = 8'h34,
                           A_DEST = 8'h35, A_WIN = 8'h36;
    localparam logic [7:0] NONE = 8'hFF;

    // {op, len, dest, seed, nack_at}
    localparam logic [39:0] VEC [9] = '{
        {8'h02, 8'd4,  8'h58, 8'h10, NONE},
        {8'h02, 8'd1,  8'h4B, 8'h80, NONE},
        {8'h02, 8'd16, 8'h40, 8'h05, NONE},
        {8'h02, 8'd4,  8'hFE, 8'h60, NONE},
        {8'h80, 8'd4,  8'hC2, 8'h21, NONE},
        {8'h80, 8'd2,  8'hC0, 8'h70, 8'd1},
        {8'h80, 8'd3,  8'hC4, 8'h33, 8'd0},
        {8'h02, 8'd0,  8'h10, 8'h00, NONE},
        {8'h80, 8'd0,  8'hC2, 8'h00, NONE}
    };

    logic       clk = 0, rst = 1;
    logic       host_we = 0;
    logic [7:0] host_addr = A_OP, host_wdata = 0;
    logic [7:0] host_rdata;
    logic       rf_we, i2c_valid;
    logic [7:0] rf_addr, rf_data, relay_speed, i2c_byte;
    logic [1:0] i2c_kind;
    logic       i2c_ready = 1, i2c_nack = 0;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] edata [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_write_engine u_burst_write_engine (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rf_we(rf_we),
        .rf_addr(rf_addr), .rf_data(rf_data), .relay_speed(relay_speed),
        .i2c_valid(i2c_valid), .i2c_kind(i2c_kind), .i2c_byte(i2c_byte),
        .i2c_ready(i2c_ready), .i2c_nack(i2c_nack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0; host_addr = A_OP;
    endtask

    task automatic hread(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
        host_addr = A_OP;
    endtask

    task automatic stage(input logic [7:0] len, input logic [7:0] dest,
                         input logic [7:0] seed, input int count);
        hwrite(A_LEN, len);
        hwrite(A_DEST, dest);
        for (int i = 0; i < count; i++) begin
            edata[i] = seed + 8'(i) * 8'h11;
            hwrite(A_WIN, edata[i]);
        end
    endtask

    // Observe until both busy bits clear; starts at the negedge after the trigger edge.
    task automatic watch(input bit rel, input int nlen, input logic [7:0] dest,
                         input logic [7:0] nack_at, input string tag);
        int nw = 0, nb = 0, cyc = 0, last, ekind;
        last = (int'(nack_at) <= nlen) ? int'(nack_at) : nlen;
        while (cyc < 300) begin
            #1;
            if (rf_we) begin
                chk(rf_addr == dest + 8'(nw), {tag, " R4 addr"}, rf_addr, dest + 8'(nw));
                if (nw < 16)
                    chk(rf_data == edata[nw], {tag, " R4 data"}, rf_data, edata[nw]);
                nw++;
            end
            if (i2c_valid) begin
                ekind = (nb == 0) ? 0 : (nb <= last) ? 1 : 2;
                chk(int'(i2c_kind) == ekind, {tag, " R5 kind"}, i2c_kind, ekind);
                if (nb == 0)
                    chk(i2c_byte == dest, {tag, " R5 addr byte"}, i2c_byte, dest);
                else if (nb <= last)
                    chk(i2c_byte == edata[nb-1], {tag, " R5 data byte"}, i2c_byte, edata[nb-1]);
                i2c_nack = (nb == int'(nack_at));
                nb++;
            end else begin
                i2c_nack = 0;
            end
            if ((host_rdata & 8'h82) == 0) break;
            @(negedge clk);
            cyc++;
        end
        i2c_nack = 0;
        chk(cyc < 300, {tag, " R4 completion"}, cyc, 300);
        if (rel) begin
            chk(nw == 0, {tag, " R5 no copy writes"}, nw, 0);
            chk(nb == last + 2, {tag, " R5 beat count"}, nb, last + 2);
            chk(host_rdata[0] == (int'(nack_at) <= nlen), {tag, " R6 nack flag"},
                host_rdata[0], int'(nack_at) <= nlen);
        end else begin
            chk(nw == nlen, {tag, " R4 write count"}, nw, nlen);
            chk(nb == 0, {tag, " R4 no relay beats"}, nb, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        hread(A_OP, r);    chk(r == 0, "R1 op", r, 0);
        hread(A_LEN, r);   chk(r == 0, "R1 len", r, 0);
        hread(A_DEST, r);  chk(r == 0, "R1 dest", r, 0);
        hread(A_SPEED, r); chk(r == 0, "R1 speed", r, 0);
        chk(!rf_we && !i2c_valid, "R1 outputs idle", {rf_we, i2c_valid}, 0);

        // Table-driven bursts
        foreach (VEC[v]) begin
            logic [7:0] op, len, dest, seed, na;
            {op, len, dest, seed, na} = VEC[v];
            stage(len, dest, seed, int'(len));
            hwrite(A_OP, op);
            watch(op[7], int'(len), dest, na, $sformatf("vec%0d", v));
        end

        // R6 flag cleared by the next clean relay
        stage(8'd1, 8'hC2, 8'h44, 1);
        hwrite(A_OP, 8'h80);
        watch(1, 1, 8'hC2, NONE, "R6 clear");

        // R2 clamp
        hwrite(A_LEN, 8'd20);
        hread(A_LEN, r); chk(r == 8'd16, "R2 clamp", r, 16);

        // R3 overrun ignored, R2 pointer rewind
        stage(8'd2, 8'h30, 8'hAA, 2);
        hwrite(A_WIN, 8'hCC);
        hwrite(A_OP, 8'h02);
        watch(0, 2, 8'h30, NONE, "R3 overrun");
        stage(8'd1, 8'h50, 8'hDD, 1);
        hwrite(A_OP, 8'h02);
        watch(0, 1, 8'h50, NONE, "R2 rewind");

        // R5 both bits: copy wins
        stage(8'd2, 8'h70, 8'h12, 2);
        hwrite(A_OP, 8'h82);
        watch(0, 2, 8'h70, NONE, "R5 both bits");

        // R8 speed register
        hwrite(A_SPEED, 8'h03);
        hread(A_SPEED, r); chk(r == 8'h03, "R8 readback", r, 3);
        chk(relay_speed == 8'h03, "R8 output", relay_speed, 3);

        // R7 / R9: stalled relay, writes while busy ignored
        stage(8'd2, 8'hC2, 8'h30, 2);
        i2c_ready = 0;
        hwrite(A_OP, 8'h80);
        hwrite(A_OP, 8'h02);
        hwrite(A_LEN, 8'd7);
        hwrite(A_DEST, 8'h11);
        hwrite(A_WIN, 8'h99);
        hread(A_LEN, r);  chk(r == 8'd2, "R7 len held", r, 2);
        hread(A_DEST, r); chk(r == 8'hC2, "R7 dest held", r, 8'hC2);
        hread(A_OP, r);   chk(r == 8'h80, "R7 relay still busy", r, 8'h80);
        #1;
        chk(i2c_valid && i2c_kind == 2'd0 && i2c_byte == 8'hC2, "R9 stall hold",
            {i2c_valid, i2c_kind, i2c_byte}, {1'b1, 2'd0, 8'hC2});
        chk(!rf_we, "R7 copy trigger ignored", rf_we, 0);
        @(negedge clk);
        i2c_ready = 1;
        watch(1, 2, 8'hC2, NONE, "R7 after stall");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule